// File: doc/BRIEF.md
# Strobed Write Master for an Asynchronous Memory Bus

This block turns a single-word write request from on-chip logic into one complete write cycle on an external memory bus. That bus has no clock of its own. The requester presents a 16-bit address and an 8-bit byte, and the block accepts them only while it reports itself ready.

The block then steps through a fixed order of events:

1. It puts the address on the bus.
2. After a programmable number of clocks, it starts driving the data lines.
3. After a further delay, it pulls the active-low write strobe down for a programmed width.
4. It waits for the far side to raise its acknowledge.
5. It holds the data for a short programmed time.
6. It releases the data lines, returns the address to zero and pulses a one-clock completion flag.

A programmable idle gap separates successive cycles. Every delay is a parameter counted in clock cycles, and any value below one is raised to one.

The data lines are presented as a value and a drive enable, both registered. The chip's pad ring combines them into the tri-state pin. As a result, the pins are never driven while the block is idle or held in reset.

Top module: `strobe_write_master`

## Requirements
- R1: While rst_n is low at a rising edge, the next outputs are: bus_wr_n high, bus_doe low, bus_addr zero and req_done low. After reset, req_ready is high.
- R2: A request (req_valid high) is taken only at a rising edge where req_ready is high. While a cycle is in progress, req_valid, req_addr and req_data have no effect on bus_addr or bus_dout.
- R3: From the edge that accepts a request, bus_addr shows the requested address. It stays unchanged until the cycle completes.
- R4: bus_doe stays low for exactly T_ADDR_SETUP cycles after acceptance and then rises with bus_dout equal to the requested byte. bus_wr_n then stays high for exactly T_DATA_SETUP cycles.
- R5: bus_wr_n is low for exactly T_STROBE consecutive cycles per write.
- R6: After bus_wr_n returns high, the block keeps bus_doe high and bus_wr_n high until it samples bus_ack = 1 at a rising edge. An acknowledge already high during the strobe does not shorten the strobe.
- R7: T_HOLD cycles after the edge that samples the acknowledge, bus_doe falls, bus_addr becomes zero and req_done is high for exactly one cycle.
- R8: req_ready rises exactly T_GAP cycles after the cycle in which req_done is high. A request waiting at that point is accepted at the next edge.
- R9: bus_doe is never high while req_ready is high, and bus_wr_n is never low while bus_doe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_addr | input | 16 | Address for the requested write |
| req_data | input | 8 | Byte for the requested write |
| req_ready | output | 1 | Block idle, request can be taken |
| req_done | output | 1 | One-clock completion flag |
| bus_addr | output | 16 | External address lines |
| bus_dout | output | 8 | Value for the external data lines |
| bus_doe | output | 1 | Drive enable for the external data lines |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ack | input | 1 | Acknowledge from the external device |

## Verification
A wrong phase or a wrong timer value shows at the ports within one clock. The data enable or the strobe changes a cycle early or late, or the completion flag and the ready flag appear at the wrong point. A behavioural model advances alongside the block and compares every output on every clock, so such a slip is reported in the cycle it happens.

A latched address or byte that is overwritten by a request arriving mid-cycle shows as a changed bus_addr or bus_dout while the strobe is low. Swallowed or premature acknowledges show as a strobe of the wrong width or a hold phase that starts early.

// File: rtl/wbm_pkg.sv
// Package: shared phase encoding for the strobed write master.
// Assumes: one write cycle in flight at a time; phases advance in declaration order.
package wbm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR    = 3'd1,
        PH_DATA    = 3'd2,
        PH_STROBE  = 3'd3,
        PH_ACKWAIT = 3'd4,
        PH_HOLD    = 3'd5,
        PH_GAP     = 3'd6
    } wbm_phase_t;

    // True for the phases in which the data lines are driven.
    function automatic logic drives_data(input wbm_phase_t ph);
        return (ph == PH_DATA) || (ph == PH_STROBE) ||
               (ph == PH_ACKWAIT) || (ph == PH_HOLD);
    endfunction

endpackage

// File: rtl/wbm_timer.sv
// Module: wbm_timer
// Down-counter that times one phase. Loaded with (length - 1) on phase entry;
// expired is high during the last cycle of the phase.
// Assumes: the caller loads on every phase change.
module wbm_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reload on phase entry, else count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/wbm_seq.sv
// Module: wbm_seq
// Phase sequencer of the write master: decides the next phase from the timer,
// the request and the acknowledge, and asks the timer to load each new phase.
// Assumes: all lengths are already clamped to at least one cycle.
module wbm_seq
    import wbm_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int LEN_AD  = 1,
    parameter int LEN_DS  = 1,
    parameter int LEN_PW  = 1,
    parameter int LEN_HD  = 1,
    parameter int LEN_GP  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             bus_ack,
    input  logic             expired,
    output wbm_phase_t       phase_q,
    output wbm_phase_t       phase_d,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    // Phase length minus one, as loaded into the timer.
    function automatic logic [CNT_W-1:0] len_of(input wbm_phase_t ph);
        case (ph)
            PH_ADDR:   return CNT_W'(LEN_AD - 1);
            PH_DATA:   return CNT_W'(LEN_DS - 1);
            PH_STROBE: return CNT_W'(LEN_PW - 1);
            PH_HOLD:   return CNT_W'(LEN_HD - 1);
            PH_GAP:    return CNT_W'(LEN_GP - 1);
            default:   return '0;
        endcase
    endfunction

    // Next-phase decision.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:    if (req_valid) phase_d = PH_ADDR;
            PH_ADDR:    if (expired)   phase_d = PH_DATA;
            PH_DATA:    if (expired)   phase_d = PH_STROBE;
            PH_STROBE:  if (expired)   phase_d = PH_ACKWAIT;
            PH_ACKWAIT: if (bus_ack)   phase_d = PH_HOLD;
            PH_HOLD:    if (expired)   phase_d = PH_GAP;
            PH_GAP:     if (expired)   phase_d = PH_IDLE;
            default:                   phase_d = PH_IDLE;
        endcase
    end

    assign accept   = (phase_q == PH_IDLE) && req_valid;
    assign tmr_load = (phase_d != phase_q);
    assign tmr_val  = len_of(phase_d);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    AST_ACK_HOLDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ACKWAIT && !bus_ack) |=> (phase_q == PH_ACKWAIT)); // R6
    AST_STROBE_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE && !expired) |=> (phase_q == PH_STROBE)); // R5

endmodule

// File: rtl/wbm_drive.sv
// Module: wbm_drive
// Registered bus drivers: address, data value, data drive enable, strobe and
// completion flag, all derived from the phase the sequencer enters next.
// Assumes: accept is only high in the idle phase.
module wbm_drive
    import wbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wbm_phase_t        phase_q,
    input  wbm_phase_t        phase_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_wr_n,
    output logic              req_done
);

    logic finishing;
    assign finishing = (phase_q == PH_HOLD) && (phase_d == PH_GAP);

    // Address and data capture on acceptance; address cleared when the cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
            bus_dout <= '0;
        end else if (accept) begin
            bus_addr <= req_addr;
            bus_dout <= req_data;
        end else if (finishing) begin
            bus_addr <= '0;
        end
    end

    // Control outputs registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_doe  <= 1'b0;
            bus_wr_n <= 1'b1;
            req_done <= 1'b0;
        end else begin
            bus_doe  <= drives_data(phase_d);
            bus_wr_n <= (phase_d != PH_STROBE);
            req_done <= finishing;
        end
    end

    AST_STROBE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_doe); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R7
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> (!bus_doe && bus_addr == '0)); // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe)) |-> $stable(bus_addr)); // R3
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe)) |-> $stable(bus_dout)); // R2

endmodule

// File: rtl/strobe_write_master.sv
// Module: strobe_write_master
// Performs single write cycles on an asynchronous memory bus: address, then
// data, then a low strobe pulse, wait for acknowledge, hold, release, gap.
// Assumes: the pad ring builds the tri-state pin from bus_dout and bus_doe;
// bus_ack is already synchronised to clk.
module strobe_write_master #(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int T_ADDR_SETUP  = 3,
    parameter int T_DATA_SETUP  = 2,
    parameter int T_STROBE      = 5,
    parameter int T_HOLD        = 2,
    parameter int T_GAP         = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              req_done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_wr_n,
    input  logic              bus_ack
);
    import wbm_pkg::*;

    localparam int LEN_AD = (T_ADDR_SETUP < 1) ? 1 : T_ADDR_SETUP;
    localparam int LEN_DS = (T_DATA_SETUP < 1) ? 1 : T_DATA_SETUP;
    localparam int LEN_PW = (T_STROBE     < 1) ? 1 : T_STROBE;
    localparam int LEN_HD = (T_HOLD       < 1) ? 1 : T_HOLD;
    localparam int LEN_GP = (T_GAP        < 1) ? 1 : T_GAP;
    localparam int MAX_01 = (LEN_AD > LEN_DS) ? LEN_AD : LEN_DS;
    localparam int MAX_23 = (LEN_PW > LEN_HD) ? LEN_PW : LEN_HD;
    localparam int MAX_03 = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
    localparam int MAX_LEN = (MAX_03 > LEN_GP) ? MAX_03 : LEN_GP;
    localparam int CNT_W = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

    wbm_phase_t       phase_q, phase_d;
    logic             accept, tmr_load, expired;
    logic [CNT_W-1:0] tmr_val;

    wbm_seq #(
        .CNT_W(CNT_W), .LEN_AD(LEN_AD), .LEN_DS(LEN_DS),
        .LEN_PW(LEN_PW), .LEN_HD(LEN_HD), .LEN_GP(LEN_GP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bus_ack(bus_ack),
        .expired(expired), .phase_q(phase_q), .phase_d(phase_d),
        .accept(accept), .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    wbm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(expired)
    );

    wbm_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .phase_d(phase_d),
        .accept(accept), .req_addr(req_addr), .req_data(req_data),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_wr_n(bus_wr_n), .req_done(req_done)
    );

    assign req_ready = (phase_q == PH_IDLE);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_doe && bus_wr_n)); // R9
    AST_READY_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> !req_ready); // R8

endmodule

// File: tb/sim_strobe_write_master.sv
module sim_strobe_write_master;

    localparam int TB_AD = 2;
    localparam int TB_DS = 1;
    localparam int TB_PW = 3;
    localparam int TB_HD = 2;
    localparam int TB_GP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        bus_ack = 1'b0;
    logic        req_ready, req_done, bus_doe, bus_wr_n;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    bit armed = 0;

    always #10 clk = ~clk;

    strobe_write_master #(
        .ADDR_W(16), .DATA_W(8), .T_ADDR_SETUP(TB_AD), .T_DATA_SETUP(TB_DS),
        .T_STROBE(TB_PW), .T_HOLD(TB_HD), .T_GAP(TB_GP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready), .req_done(req_done),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_wr_n(bus_wr_n), .bus_ack(bus_ack)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 address, 2 data, 3 strobe, 4 wait, 5 hold, 6 gap
    int          m_ph = 0;
    int          m_rem = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    bit          m_done = 0;

    always @(posedge clk) begin
        armed <= 1'b1;
        if (!rst_n) begin
            m_ph <= 0; m_rem <= 0; m_addr <= '0; m_data <= '0; m_done <= 0;
        end else begin
            m_done <= 0;
            if (m_ph == 0) begin
                if (req_valid) begin
                    m_ph <= 1; m_rem <= TB_AD; m_addr <= req_addr; m_data <= req_data;
                end
            end else if (m_ph == 4) begin
                if (bus_ack) begin m_ph <= 5; m_rem <= TB_HD; end
            end else if (m_rem > 1) begin
                m_rem <= m_rem - 1;
            end else begin
                case (m_ph)
                    1: begin m_ph <= 2; m_rem <= TB_DS; end
                    2: begin m_ph <= 3; m_rem <= TB_PW; end
                    3: begin m_ph <= 4; end
                    5: begin m_ph <= 6; m_rem <= TB_GP; m_addr <= '0; m_done <= 1; end
                    default: m_ph <= 0;
                endcase
            end
        end
    end

    // Per-clock comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (armed && !finished) begin
            check(req_ready == (m_ph == 0), "R8", "req_ready", req_ready, m_ph == 0);
            check(req_done == m_done, "R7", "req_done", req_done, m_done);
            check(bus_wr_n == (m_ph != 3), "R5", "bus_wr_n", bus_wr_n, m_ph != 3);
            check(bus_doe == (m_ph >= 2 && m_ph <= 5), "R4", "bus_doe", bus_doe,
                  (m_ph >= 2 && m_ph <= 5));
            check(bus_addr == m_addr, "R3", "bus_addr", bus_addr, m_addr);
            if (bus_doe) check(bus_dout == m_data, "R2", "bus_dout", bus_dout, m_data);
            check(!(req_ready && bus_doe) && !(!bus_wr_n && !bus_doe), "R9",
                  "idle/strobe drive", {req_ready, bus_doe, bus_wr_n}, 0);
        end
    end

    task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                            input int ack_lag, input bit early, input bit spam);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        if (early) bus_ack = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (spam) begin req_addr = a ^ 16'h0F0F; req_data = ~d; end
        else req_valid = 1'b0;
        check(bus_addr == a, "R3", "address after accept", bus_addr, a);
        n = 0;
        while (!bus_doe) begin n++; @(negedge clk); end
        check(n == TB_AD, "R4", "address-to-data cycles", n, TB_AD);
        check(bus_dout == d, "R4", "data value", bus_dout, d);
        n = 0;
        while (bus_wr_n) begin n++; @(negedge clk); end
        check(n == TB_DS, "R4", "data-to-strobe cycles", n, TB_DS);
        n = 0;
        while (!bus_wr_n) begin
            n++;
            if (spam) begin
                check(bus_addr == a, "R2", "address during busy request", bus_addr, a);
                check(bus_dout == d, "R2", "data during busy request", bus_dout, d);
            end
            @(negedge clk);
        end
        check(n == TB_PW, "R5", "strobe width", n, TB_PW);
        req_valid = 1'b0;
        for (int i = 0; i < ack_lag; i++) begin
            check(bus_doe && bus_wr_n && !req_done, "R6", "waiting for ack",
                  {bus_doe, bus_wr_n, req_done}, 3'b110);
            @(negedge clk);
        end
        bus_ack = 1'b1;
        n = 0;
        while (!req_done) begin n++; @(negedge clk); end
        check(n == TB_HD + 1 || early, "R7", "ack-to-done cycles", n, TB_HD + 1);
        bus_ack = 1'b0;
        check(!bus_doe && bus_addr == 16'h0, "R7", "release at done",
              {bus_doe, bus_addr}, 0);
        n = 0;
        while (!req_ready) begin n++; @(negedge clk); end
        check(n == TB_GP, "R8", "gap cycles", n, TB_GP);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(bus_wr_n && !bus_doe && bus_addr == 0 && !req_done, "R1", "reset outputs",
              {bus_wr_n, bus_doe, req_done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1", "ready after reset", req_ready, 1);
        do_write(16'h1234, 8'hA5, 4, 0, 0);
        do_write(16'h0000, 8'h3C, 0, 0, 0);
        do_write(16'hFFFF, 8'h5A, 2, 1, 0);
        do_write(16'hBEEF, 8'h81, 1, 0, 1);
        do_write(16'h8001, 8'h7E, 3, 0, 0);
        // reset in the middle of a cycle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h4242; req_data = 8'h24;
        @(negedge clk); req_valid = 1'b0;
        repeat (TB_AD + 1) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(bus_wr_n && !bus_doe && bus_addr == 0, "R1", "mid-cycle reset",
              {bus_wr_n, bus_doe}, 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule